// File: doc/BRIEF.md
# Serial Two-Wire Slave Memory Controller with Write Gating

This block is the bidirectional-mode slave engine for a 128-byte, byte-wide memory reached over a two-wire I2C-compatible bus. It synchronizes the clock and data lines, finds START and STOP conditions, decodes the device select byte, and runs write and read transactions against an external single-port memory. A master can write one byte or a page of up to eight bytes, and can read the current address, a random address, or a sequential stream of bytes.

Written bytes are collected in a page buffer. They reach the memory only if the write-enable input is high at the STOP that closes the command. A commit starts a self-timed program interval, counted in clock cycles. During that interval the buffer drains into the memory and the slave ignores its own device select. The mode-active input holds the engine idle and keeps the data line released while bidirectional operation is not selected.

Top module: `i2c_gated_mem_slave`

## Requirements
- R1: After reset the data-line pull-down (sda_oe_o) is released and no memory write is issued.
- R2: Bytes are received MSB first. A device select byte is acknowledged only if bits 7..4 equal 1010, bits 3..1 equal DEV_SEL (default 000) and no program interval is running. Bit 0 selects read (1) or write (0). Any other select byte is not acknowledged.
- R3: In a write command, the byte after the select byte loads the address counter from its low 7 bits. Each following data byte is acknowledged. A STOP with wr_en_i = 1 writes the received bytes to memory.
- R4: During a write, the low 3 address bits advance and wrap inside the 8-byte page while the upper 4 bits stay fixed. A ninth or later byte overwrites the buffered byte at its wrapped location.
- R5: If wr_en_i = 0 at the closing STOP, the memory is not changed and no program interval starts.
- R6: A committed write starts a program interval of TWR_CYCLES clock cycles. Memory writes happen only inside this interval, and a select byte sent during it is not acknowledged.
- R7: A read command returns the byte at the address counter, then increments it. After a page write, the counter points one past the last written location, wrapped inside the page.
- R8: A write command that sets the address, followed by a repeated START and a read select, returns the byte at that address.
- R9: While the master acknowledges, reads continue with an incrementing address that wraps from 7Fh to 00h. After a missing master acknowledge the slave releases the data line and stops sending.
- R10: A START or STOP in the middle of a byte abandons it and leaves the engine waiting for a select byte or idle. A write command ended by a repeated START discards its buffered bytes.
- R11: While mode_act_i = 0, nothing is acknowledged, the data line stays released and no write is committed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| mode_act_i | input | 1 | Bidirectional mode active |
| scl_i | input | 1 | Serial clock line level |
| sda_i | input | 1 | Serial data line level |
| sda_oe_o | output | 1 | Pull data line low when 1 |
| wr_en_i | input | 1 | Write enable, sampled at STOP |
| mem_addr_o | output | 7 | Memory address |
| mem_we_o | output | 1 | Memory write strobe |
| mem_wdata_o | output | 8 | Memory write data |
| mem_rdata_i | input | 8 | Memory read data, combinational on mem_addr_o |

## Verification
The hardest case to reach is the wrapped page write. The bench must send more than eight data bytes starting partway into a page, let the program interval run out, and then observe both the overwritten and the untouched locations. It does this with a ten-byte write starting at offset 5, a current-address read and a sequential read over the whole page. It also probes the busy window by sending a select byte straight after a commit. Mid-byte START and STOP are produced by cutting a byte short after three or four bits.

// File: rtl/i2cm_pkg.sv
package i2cm_pkg;
  typedef enum logic [3:0] {
    ST_IDLE, ST_DEV, ST_DACK, ST_ADDR, ST_AACK, ST_WDAT, ST_WACK, ST_TX, ST_RACK
  } i2cm_st_e;
endpackage

// File: rtl/i2cm_line_sync.sv
module i2cm_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_o,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o
);
  logic [STAGES-1:0] scl_ff, sda_ff;
  logic scl_p, sda_p;
  logic scl_s, sda_s;

  assign scl_s = scl_ff[STAGES-1];
  assign sda_s = sda_ff[STAGES-1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_ff <= '1;
      sda_ff <= '1;
      scl_p  <= 1'b1;
      sda_p  <= 1'b1;
    end else begin
      scl_ff <= {scl_ff[STAGES-2:0], scl_i};
      sda_ff <= {sda_ff[STAGES-2:0], sda_i};
      scl_p  <= scl_s;
      sda_p  <= sda_s;
    end
  end

  assign sda_o      = sda_s;
  assign scl_rise_o = scl_s & ~scl_p;
  assign scl_fall_o = ~scl_s & scl_p;
  assign start_o    = scl_s & scl_p & sda_p & ~sda_s;
  assign stop_o     = scl_s & scl_p & ~sda_p & sda_s;
endmodule

// File: rtl/i2cm_page_buf.sv
module i2cm_page_buf #(
  parameter int DEPTH = 8,
  parameter int DW    = 8,
  localparam int IW   = $clog2(DEPTH)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clr_i,
  input  logic          put_i,
  input  logic [IW-1:0] put_idx_i,
  input  logic [DW-1:0] put_data_i,
  input  logic          drain_i,
  output logic          act_o,
  output logic          we_o,
  output logic [IW-1:0] idx_o,
  output logic [DW-1:0] data_o
);
  logic [DW-1:0]    dat_q [DEPTH];
  logic [DEPTH-1:0] vld_q;
  logic             act_q;
  logic [IW-1:0]    idx_q;

  for (genvar i = 0; i < DEPTH; i++) begin : g_ent
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        dat_q[i] <= '0;
        vld_q[i] <= 1'b0;
      end else if (put_i && put_idx_i == IW'(i)) begin
        dat_q[i] <= put_data_i;
        vld_q[i] <= 1'b1;
      end else if ((clr_i && !act_q) || (act_q && idx_q == IW'(i))) begin
        vld_q[i] <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_q <= 1'b0;
      idx_q <= '0;
    end else if (drain_i) begin
      act_q <= 1'b1;
      idx_q <= '0;
    end else if (act_q) begin
      idx_q <= idx_q + IW'(1);
      if (idx_q == IW'(DEPTH - 1)) act_q <= 1'b0;
    end
  end

  assign act_o  = act_q;
  assign we_o   = act_q & vld_q[idx_q];
  assign idx_o  = idx_q;
  assign data_o = dat_q[idx_q];

  a_r6_no_put_while_drain: assert property (@(posedge clk_i) disable iff (!rst_ni)
    put_i |-> !act_q);
endmodule

// File: rtl/i2cm_wr_timer.sv
module i2cm_wr_timer #(
  parameter int CYCLES = 1000000,
  localparam int CW    = $clog2(CYCLES + 1)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic load_i,
  output logic busy_o
);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              cnt_q <= '0;
    else if (load_i)          cnt_q <= CW'(CYCLES);
    else if (cnt_q != '0)     cnt_q <= cnt_q - CW'(1);
  end

  assign busy_o = (cnt_q != '0);

  a_r6_load_when_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |-> !busy_o);
endmodule

// File: rtl/i2c_gated_mem_slave.sv
module i2c_gated_mem_slave
  import i2cm_pkg::*;
#(
  parameter int         MEM_AW     = 7,
  parameter int         PAGE_BYTES = 8,
  parameter logic [3:0] DEV_CODE   = 4'b1010,
  parameter logic [2:0] DEV_SEL    = 3'b000,
  parameter int         TWR_CYCLES = 1000000
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              mode_act_i,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              sda_oe_o,
  input  logic              wr_en_i,
  output logic [MEM_AW-1:0] mem_addr_o,
  output logic              mem_we_o,
  output logic [7:0]        mem_wdata_o,
  input  logic [7:0]        mem_rdata_i
);
  localparam int AW  = MEM_AW;
  localparam int PAW = $clog2(PAGE_BYTES);

  logic sda_s, scl_rise, scl_fall, start_det, stop_det;
  logic busy, commit, buf_clr, buf_put, buf_act;
  logic [PAW-1:0] buf_idx;

  i2cm_st_e         st_q;
  logic [3:0]       bit_cnt_q;
  logic [7:0]       shreg_q;
  logic [AW-1:0]    ptr_q;
  logic [AW-PAW-1:0] wr_page_q;
  logic             rd_q, mack_q, pending_q, sda_oe_q;

  i2cm_line_sync #(.STAGES(2)) i_sync (
    .clk_i, .rst_ni, .scl_i, .sda_i,
    .sda_o(sda_s), .scl_rise_o(scl_rise), .scl_fall_o(scl_fall),
    .start_o(start_det), .stop_o(stop_det)
  );

  assign commit  = mode_act_i & stop_det & pending_q & wr_en_i;
  assign buf_clr = start_det | (stop_det & ~commit) | ~mode_act_i;
  assign buf_put = mode_act_i & ~start_det & ~stop_det & (st_q == ST_WDAT)
                   & scl_fall & (bit_cnt_q == 4'd8);

  i2cm_page_buf #(.DEPTH(PAGE_BYTES), .DW(8)) i_buf (
    .clk_i, .rst_ni,
    .clr_i(buf_clr), .put_i(buf_put), .put_idx_i(ptr_q[PAW-1:0]),
    .put_data_i(shreg_q), .drain_i(commit),
    .act_o(buf_act), .we_o(mem_we_o), .idx_o(buf_idx), .data_o(mem_wdata_o)
  );

  i2cm_wr_timer #(.CYCLES(TWR_CYCLES)) i_tmr (
    .clk_i, .rst_ni, .load_i(commit), .busy_o(busy)
  );

  assign mem_addr_o = buf_act ? {wr_page_q, buf_idx} : ptr_q;
  assign sda_oe_o   = sda_oe_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) wr_page_q <= '0;
    else if (commit) wr_page_q <= ptr_q[AW-1:PAW];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q <= ST_IDLE; bit_cnt_q <= '0; shreg_q <= '0; ptr_q <= '0;
      rd_q <= 1'b0; mack_q <= 1'b0; pending_q <= 1'b0; sda_oe_q <= 1'b0;
    end else if (!mode_act_i || stop_det) begin
      st_q <= ST_IDLE; bit_cnt_q <= '0; pending_q <= 1'b0; sda_oe_q <= 1'b0;
    end else if (start_det) begin
      st_q <= ST_DEV; bit_cnt_q <= '0; pending_q <= 1'b0; sda_oe_q <= 1'b0;
    end else begin
      unique case (st_q)
        ST_DEV, ST_ADDR, ST_WDAT: begin
          if (scl_rise && bit_cnt_q != 4'd8) begin
            shreg_q   <= {shreg_q[6:0], sda_s};
            bit_cnt_q <= bit_cnt_q + 4'd1;
          end else if (scl_fall && bit_cnt_q == 4'd8) begin
            bit_cnt_q <= '0;
            if (st_q == ST_DEV) begin
              if (shreg_q[7:4] == DEV_CODE && shreg_q[3:1] == DEV_SEL && !busy) begin
                rd_q <= shreg_q[0]; sda_oe_q <= 1'b1; st_q <= ST_DACK;
              end else begin
                st_q <= ST_IDLE;
              end
            end else if (st_q == ST_ADDR) begin
              ptr_q <= shreg_q[AW-1:0]; sda_oe_q <= 1'b1; st_q <= ST_AACK;
            end else begin
              // page-local increment: upper bits fixed
              ptr_q <= {ptr_q[AW-1:PAW], ptr_q[PAW-1:0] + PAW'(1)};
              pending_q <= 1'b1; sda_oe_q <= 1'b1; st_q <= ST_WACK;
            end
          end
        end
        ST_DACK, ST_RACK: begin
          if (scl_rise) mack_q <= ~sda_s;
          if (scl_fall) begin
            if ((st_q == ST_DACK && rd_q) || (st_q == ST_RACK && mack_q)) begin
              shreg_q   <= mem_rdata_i;
              ptr_q     <= ptr_q + AW'(1);
              sda_oe_q  <= ~mem_rdata_i[7];
              bit_cnt_q <= 4'd1;
              st_q      <= ST_TX;
            end else begin
              sda_oe_q <= 1'b0;
              st_q     <= (st_q == ST_DACK) ? ST_ADDR : ST_IDLE;
            end
          end
        end
        ST_AACK, ST_WACK: begin
          if (scl_fall) begin
            sda_oe_q <= 1'b0; st_q <= ST_WDAT;
          end
        end
        ST_TX: begin
          if (scl_fall) begin
            if (bit_cnt_q == 4'd8) begin
              sda_oe_q <= 1'b0; bit_cnt_q <= '0; st_q <= ST_RACK;
            end else begin
              shreg_q   <= {shreg_q[6:0], 1'b0};
              sda_oe_q  <= ~shreg_q[6];
              bit_cnt_q <= bit_cnt_q + 4'd1;
            end
          end
        end
        default: ;
      endcase
    end
  end

  a_r1_idle_released: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_IDLE) |-> !sda_oe_o);
  a_r6_write_in_interval: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we_o |-> busy);
  a_r6_no_ack_while_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_DACK) |-> !busy);
  a_r5_commit_needs_enable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy) |-> $past(wr_en_i));
  a_r11_released_inactive: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mode_act_i |=> !sda_oe_o);
endmodule

// File: tb/test_i2c_gated_mem_slave.sv
module test_i2c_gated_mem_slave;
  localparam int Q   = 5;
  localparam int TWR = 300;

  logic clk = 1'b0, rst_n = 1'b0;
  logic mode_act = 1'b1, wr_en = 1'b1, scl_m = 1'b1, sda_m = 1'b1;
  logic sda_oe, mem_we, bus_sda;
  logic [6:0] mem_addr;
  logic [7:0] mem_wdata, mem_rdata;
  logic [7:0] mem [128];
  logic [7:0] exp_mem [128];
  int checks = 0, errors = 0;

  always #5 clk = ~clk;

  assign bus_sda = sda_m & ~sda_oe;
  assign mem_rdata = mem[mem_addr];

  always_ff @(posedge clk) if (mem_we) mem[mem_addr] <= mem_wdata;

  i2c_gated_mem_slave #(.TWR_CYCLES(TWR)) i_i2c_gated_mem_slave (
    .clk_i(clk), .rst_ni(rst_n), .mode_act_i(mode_act), .scl_i(scl_m),
    .sda_i(bus_sda), .sda_oe_o(sda_oe), .wr_en_i(wr_en), .mem_addr_o(mem_addr),
    .mem_we_o(mem_we), .mem_wdata_o(mem_wdata), .mem_rdata_i(mem_rdata)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic qw(); repeat (Q) @(negedge clk); endtask
  task automatic i2c_start(); sda_m = 1; qw(); scl_m = 1; qw(); sda_m = 0; qw(); scl_m = 0; qw(); endtask
  task automatic i2c_stop(); sda_m = 0; qw(); scl_m = 1; qw(); sda_m = 1; qw(); qw(); endtask
  task automatic put_bits(input logic [7:0] b, input int n);
    for (int i = 7; i > 7 - n; i--) begin
      sda_m = b[i]; qw(); scl_m = 1; qw(); qw(); scl_m = 0; qw();
    end
  endtask
  task automatic put_byte(input logic [7:0] b, output logic ack);
    put_bits(b, 8);
    sda_m = 1; qw(); scl_m = 1; qw(); ack = ~bus_sda; qw(); scl_m = 0; qw();
  endtask
  task automatic get_byte(input logic mack, output logic [7:0] b);
    b = '0;
    for (int i = 0; i < 8; i++) begin
      sda_m = 1; qw(); scl_m = 1; qw(); b = {b[6:0], bus_sda}; qw(); scl_m = 0; qw();
    end
    sda_m = ~mack; qw(); scl_m = 1; qw(); qw(); scl_m = 0; qw(); sda_m = 1;
  endtask

  // random read of n bytes, each compared against the expectation model
  task automatic rd_random(input string req, input logic [6:0] a, input int n);
    logic ack;
    logic [7:0] d;
    i2c_start(); put_byte(8'hA0, ack); chk(req, {7'd0, ack}, 8'd1);
    put_byte({1'b0, a}, ack);
    i2c_start(); put_byte(8'hA1, ack); chk(req, {7'd0, ack}, 8'd1);
    for (int k = 0; k < n; k++) begin
      get_byte(k != n - 1, d);
      chk(req, d, exp_mem[7'(a + 7'(k))]);
    end
    i2c_stop();
  endtask

  initial begin
    logic ack;
    logic [7:0] d;
    for (int i = 0; i < 128; i++) begin
      mem[i] = 8'(i * 3 + 5);
      exp_mem[i] = 8'(i * 3 + 5);
    end
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1 sda_oe", {7'd0, sda_oe}, 8'd0);
    chk("R1 we", {7'd0, mem_we}, 8'd0);

    // R2: sweep every write-select value
    for (int v = 0; v < 128; v++) begin
      i2c_start(); put_byte({7'(v), 1'b0}, ack); i2c_stop();
      chk("R2 select ack", {7'd0, ack}, {7'd0, v == 'h50});
    end

    // R3 byte write, then R6 busy window
    i2c_start(); put_byte(8'hA0, ack); put_byte(8'h10, ack);
    put_byte(8'hA5, ack); chk("R3 data ack", {7'd0, ack}, 8'd1);
    i2c_stop(); exp_mem[16] = 8'hA5;
    i2c_start(); put_byte(8'hA0, ack); i2c_stop();
    chk("R6 no ack while busy", {7'd0, ack}, 8'd0);
    repeat (TWR + 50) @(negedge clk);
    rd_random("R8 R3 random read", 7'h10, 1);

    // R4 ten bytes from 0x2D, wrapping in page 0x28..0x2F
    i2c_start(); put_byte(8'hA0, ack); put_byte(8'h2D, ack);
    for (int k = 0; k < 10; k++) begin
      put_byte(8'(8'hC0 + k), ack);
      exp_mem[{4'h5, 3'(3'd5 + 3'(k))}] = 8'(8'hC0 + k);
    end
    i2c_stop();
    repeat (TWR + 50) @(negedge clk);
    // R7 current address is 0x2F after the wrapped write
    i2c_start(); put_byte(8'hA1, ack); get_byte(1'b0, d); i2c_stop();
    chk("R7 current read", d, exp_mem[7'h2F]);
    rd_random("R4 R9 page contents", 7'h28, 9);

    // R5 write with enable low
    wr_en = 0;
    i2c_start(); put_byte(8'hA0, ack); put_byte(8'h40, ack); put_byte(8'h11, ack); i2c_stop();
    wr_en = 1;
    rd_random("R5 no write, no busy", 7'h40, 1);

    // R9 wrap 7F -> 00 and release after nack
    rd_random("R9 wrap", 7'h7E, 4);
    chk("R9 released", {7'd0, sda_oe}, 8'd0);

    // R10 mid-byte STOP, then select works
    i2c_start(); put_bits(8'hA0, 3); i2c_stop();
    i2c_start(); put_byte(8'hA0, ack); i2c_stop();
    chk("R10 after mid STOP", {7'd0, ack}, 8'd1);
    // R10 mid-byte START, then read at loaded address
    i2c_start(); put_byte(8'hA0, ack); put_byte(8'h50, ack); put_bits(8'hFF, 4);
    i2c_start(); put_byte(8'hA1, ack); chk("R10 after mid START", {7'd0, ack}, 8'd1);
    get_byte(1'b0, d); i2c_stop();
    chk("R10 partial discarded", d, exp_mem[7'h50]);
    // R10 full byte then repeated START: discarded
    i2c_start(); put_byte(8'hA0, ack); put_byte(8'h51, ack); put_byte(8'h77, ack);
    i2c_start(); i2c_stop();
    rd_random("R10 buffer discarded", 7'h51, 1);

    // R11 inactive mode
    mode_act = 0;
    i2c_start(); put_byte(8'hA0, ack);
    chk("R11 no ack", {7'd0, ack}, 8'd0);
    put_byte(8'h60, ack); put_byte(8'h99, ack); i2c_stop();
    chk("R11 released", {7'd0, sda_oe}, 8'd0);
    mode_act = 1;
    repeat (4) @(negedge clk);
    rd_random("R11 no write", 7'h60, 1);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule